// File: doc/BRIEF.md
# Interrupt Vector and Acknowledge Resolver

This block answers the two vector reads of an interrupt controller. Each source has a pending bit, an enable bit, a channel bit that puts it on the fast channel or the normal channel, and a 4-bit priority. All of these come from a separate register bank. When software reads the normal vector word, the block finds the qualifying normal source with the highest priority. When software reads the fast vector word, it finds the qualifying fast source with the lowest index. It returns a 32-bit status word. In the same cycle it sends a one-cycle clear pulse with the winner's index, which tells the bank to drop that pending bit. The read is therefore destructive.

Each channel has its own read strobe, which the requester holds until `done` is returned. Arbitration runs through a combinational comparison tree, one per channel. The result is registered on the edge that accepts the strobe. Each strobe assertion produces exactly one answer. A new read is accepted only after the strobe has been released. The bank keeps ownership of the pending state: a source whose input is still high is marked pending again after its clear, and it competes again on the next read.

Top module: `irq_ack_resolver`

## Requirements
- R1: After reset `done` and `clr_valid` are low and `result` is 0xFFFFFFFF.
- R2: A source takes part in normal arbitration only if it is pending, enabled and its channel bit is 0. A source whose channel bit is 1 takes part only in fast arbitration, and only if it is also pending and enabled.
- R3: The normal winner is the qualifying source with the largest priority value. The priority of source i is bits [4i+3:4i] of `prio_flat`. Priority 0 still qualifies.
- R4: When several qualifying normal sources share the largest priority, the highest-numbered of them wins.
- R5: The normal result word holds the winner's index, zero-extended, in bits 31:16, zeros in bits 15:4, and the winner's priority in bits 3:0.
- R6: The fast winner is the lowest-numbered qualifying fast source. The fast result word is its index, zero-extended to 32 bits.
- R7: When no source qualifies on the channel being read, `result` is 0xFFFFFFFF and `clr_valid` stays low.
- R8: When a read has a winner, `clr_valid` is high for exactly the one cycle in which `done` is high, and `clr_idx` carries the winner's index.
- R9: `done` rises in the cycle after the edge that samples a strobe and lasts one cycle. While the strobe stays high no further `done` is given, and a new read starts only after both strobes have been low at a clock edge.
- R10: If both strobes are high at the accepting edge, the normal channel is served.
- R11: Each read arbitrates on the inputs present at its accepting edge. A source that is pending again after its clear therefore wins the next read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pending | input | NSRC | Pending bits from the bank |
| enabled | input | NSRC | Enable bits from the bank |
| fast_sel | input | NSRC | Channel bit per source, 1 = fast |
| prio_flat | input | NSRC*4 | Packed 4-bit priorities, source i at [4i+3:4i] |
| rd_norm | input | 1 | Normal vector read strobe, held until done |
| rd_fast | input | 1 | Fast vector read strobe, held until done |
| done | output | 1 | One-cycle read completion |
| result | output | 32 | Status word of the last read |
| clr_valid | output | 1 | Pending-clear pulse to the bank |
| clr_idx | output | IDXW | Index of the source to clear |

## Verification
A wrong comparison at any node of a tree shows up as a wrong index or priority in `result` and `clr_idx` in the cycle `done` rises. The bank model then clears the wrong bit, so the error also spreads into later reads. A control state that fails to wait for the strobe release shows up as a second `done` or a second clear pulse in the hold cycle, one cycle after the first. A pulse on `clr_valid` at any time other than a winning answer would drop a pending bit silently. It is therefore checked against `done` on every clock.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam int PRIO_W  = 4;
    localparam int IDX_FLD = 16;
    localparam logic [31:0] NO_WINNER = 32'hFFFF_FFFF;

    typedef struct packed {
        logic               valid;
        logic [PRIO_W-1:0]  prio;
        logic [IDX_FLD-1:0] idx;
    } cand_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHOW = 2'd1,
        ST_HOLD = 2'd2
    } ctl_state_t;

    // higher-index operand wins ties on priority
    function automatic cand_t pick_by_prio(cand_t lo, cand_t hi);
        if (hi.valid && (!lo.valid || hi.prio >= lo.prio))
            return hi;
        return lo;
    endfunction

    // lower-index operand wins whenever valid
    function automatic cand_t pick_lowest(cand_t lo, cand_t hi);
        if (lo.valid)
            return lo;
        return hi;
    endfunction

    function automatic logic [31:0] norm_word(cand_t c);
        return {c.idx, {(16-PRIO_W){1'b0}}, c.prio};
    endfunction

    function automatic logic [31:0] fast_word(cand_t c);
        return {16'h0000, c.idx};
    endfunction

endpackage

// File: rtl/irq_res_tree.sv
module irq_res_tree
    import irq_res_pkg::*;
#(
    parameter int NSRC    = 64,
    parameter bit FAST_CH = 1'b0
) (
    input  logic [NSRC-1:0]        pending,
    input  logic [NSRC-1:0]        enabled,
    input  logic [NSRC-1:0]        fast_sel,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output cand_t                  winner
);
    localparam int LV    = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int NP    = 1 << LV;
    localparam int NNODE = 2 * NP - 1;

    cand_t node [NNODE];

    for (genvar i = 0; i < NP; i++) begin : g_leaf
        if (i < NSRC) begin : g_real
            logic chan_ok;
            assign chan_ok = FAST_CH ? fast_sel[i] : ~fast_sel[i];
            assign node[NP-1+i].valid = pending[i] & enabled[i] & chan_ok;
            assign node[NP-1+i].prio  = prio_flat[i*PRIO_W +: PRIO_W];
            assign node[NP-1+i].idx   = IDX_FLD'(i);
        end else begin : g_pad
            assign node[NP-1+i] = '0;
        end
    end

    for (genvar n = 0; n < NP - 1; n++) begin : g_node
        if (FAST_CH) begin : g_low
            assign node[n] = pick_lowest(node[2*n+1], node[2*n+2]);
        end else begin : g_pri
            assign node[n] = pick_by_prio(node[2*n+1], node[2*n+2]);
        end
    end

    assign winner = node[0];

endmodule

// File: rtl/irq_res_ctrl.sv
module irq_res_ctrl
    import irq_res_pkg::*;
#(
    parameter int IDXW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_norm,
    input  logic            rd_fast,
    input  cand_t           norm_win,
    input  cand_t           fast_win,
    output logic            done,
    output logic [31:0]     result,
    output logic            clr_valid,
    output logic [IDXW-1:0] clr_idx
);
    ctl_state_t      state_q;
    logic [31:0]     word_q;
    logic            clr_q;
    logic [IDXW-1:0] idx_q;
    logic            any_rd;
    cand_t           sel;
    logic [31:0]     sel_word;

    assign any_rd = rd_norm | rd_fast;

    always_comb begin
        sel      = rd_norm ? norm_win : fast_win;
        sel_word = rd_norm ? norm_word(norm_win) : fast_word(fast_win);
        if (!sel.valid)
            sel_word = NO_WINNER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= NO_WINNER;
            clr_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    clr_q <= 1'b0;
                    if (any_rd) begin
                        word_q  <= sel_word;
                        clr_q   <= sel.valid;
                        idx_q   <= IDXW'(sel.idx);
                        state_q <= ST_SHOW;
                    end
                end
                ST_SHOW: begin
                    clr_q   <= 1'b0;
                    state_q <= any_rd ? ST_HOLD : ST_IDLE;
                end
                ST_HOLD: begin
                    clr_q <= 1'b0;
                    if (!any_rd)
                        state_q <= ST_IDLE;
                end
                default: begin
                    clr_q   <= 1'b0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign done      = (state_q == ST_SHOW);
    assign result    = word_q;
    assign clr_valid = clr_q;
    assign clr_idx   = idx_q;

endmodule

// File: rtl/irq_ack_resolver.sv
module irq_ack_resolver
    import irq_res_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        pending,
    input  logic [NSRC-1:0]        enabled,
    input  logic [NSRC-1:0]        fast_sel,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    input  logic                   rd_norm,
    input  logic                   rd_fast,
    output logic                   done,
    output logic [31:0]            result,
    output logic                   clr_valid,
    output logic [IDXW-1:0]        clr_idx
);
    cand_t norm_win;
    cand_t fast_win;

    irq_res_tree #(.NSRC(NSRC), .FAST_CH(1'b0)) u_norm_tree (
        .pending  (pending),
        .enabled  (enabled),
        .fast_sel (fast_sel),
        .prio_flat(prio_flat),
        .winner   (norm_win)
    );

    irq_res_tree #(.NSRC(NSRC), .FAST_CH(1'b1)) u_fast_tree (
        .pending  (pending),
        .enabled  (enabled),
        .fast_sel (fast_sel),
        .prio_flat(prio_flat),
        .winner   (fast_win)
    );

    irq_res_ctrl #(.IDXW(IDXW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rd_norm  (rd_norm),
        .rd_fast  (rd_fast),
        .norm_win (norm_win),
        .fast_win (fast_win),
        .done     (done),
        .result   (result),
        .clr_valid(clr_valid),
        .clr_idx  (clr_idx)
    );

endmodule

// File: rtl/irq_res_chk.sv
module irq_res_chk #(
    parameter int IDXW = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_norm,
    input logic            rd_fast,
    input logic            done,
    input logic [31:0]     result,
    input logic            clr_valid,
    input logic [IDXW-1:0] clr_idx
);
    AST_CLR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        clr_valid |-> done); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(rd_norm || rd_fast)); // R9

    AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (rst)
        (done && !clr_valid) |-> (result == 32'hFFFF_FFFF)); // R7

    AST_NORM_INDEX_FIELD: assert property (@(posedge clk) disable iff (rst)
        (done && clr_valid && $past(rd_norm)) |->
            (result[31:16] == 16'(clr_idx) && result[15:4] == 12'h000)); // R5

    AST_FAST_INDEX_WORD: assert property (@(posedge clk) disable iff (rst)
        (done && clr_valid && $past(!rd_norm)) |-> (result == 32'(clr_idx))); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(result)); // R9

endmodule

bind irq_ack_resolver irq_res_chk #(.IDXW(IDXW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_norm  (rd_norm),
    .rd_fast  (rd_fast),
    .done     (done),
    .result   (result),
    .clr_valid(clr_valid),
    .clr_idx  (clr_idx)
);

// File: tb/tb_irq_ack_resolver.sv
`timescale 1ns/1ps
module tb_irq_ack_resolver;
    localparam int N  = 64;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]   pend = '0, en = '0, fs = '0, lvl = '0;
    logic [N*4-1:0] pr = '0;
    logic rd_n = 1'b0, rd_f = 1'b0;
    logic done, clr_valid;
    logic [31:0] result;
    logic [IW-1:0] clr_idx;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    irq_ack_resolver #(.NSRC(N)) dut (
        .clk(clk), .rst(rst), .pending(pend), .enabled(en), .fast_sel(fs),
        .prio_flat(pr), .rd_norm(rd_n), .rd_fast(rd_f), .done(done),
        .result(result), .clr_valid(clr_valid), .clr_idx(clr_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural linear scan
    task automatic ref_arb(input bit nrm, output logic [31:0] w,
                           output bit v, output int idx);
        int best = -1;
        v = 0; idx = 0; w = 32'hFFFF_FFFF;
        if (nrm) begin
            for (int i = N - 1; i >= 0; i--)
                if (pend[i] && en[i] && !fs[i] && int'(pr[i*4 +: 4]) > best) begin
                    best = int'(pr[i*4 +: 4]); idx = i; v = 1;
                end
            if (v) w = (idx << 16) | best;
        end else begin
            for (int i = N - 1; i >= 0; i--)
                if (pend[i] && en[i] && fs[i]) begin idx = i; v = 1; end
            if (v) w = idx;
        end
    endtask

    task automatic src(input int i, input bit fast, input int p, input bit level);
        pend[i] = 1'b1; en[i] = 1'b1; fs[i] = fast;
        pr[i*4 +: 4] = 4'(p); lvl[i] = level;
    endtask

    task automatic do_read(input bit n, input bit f, input string req);
        logic [31:0] w; bit v; int idx;
        ref_arb(n, w, v, idx);
        rd_n = n; rd_f = f;
        @(negedge clk);
        chk(done === 1'b1, "R9", "done after strobe", 32'(done), 1);
        chk(result === w, req, "result word", result, w);
        chk(clr_valid === v, v ? "R8" : "R7", "clr_valid", 32'(clr_valid), 32'(v));
        if (v) chk(clr_idx === IW'(idx), "R8", "clr_idx", 32'(clr_idx), idx);
        @(negedge clk);
        chk(done === 1'b0 && clr_valid === 1'b0, "R9", "no repeat while held",
            {30'b0, done, clr_valid}, 0);
        if (v) pend[idx] = lvl[idx];
        rd_n = 1'b0; rd_f = 1'b0;
        @(negedge clk);
        chk(done === 1'b0, "R9", "idle after release", 32'(done), 0);
    endtask

    initial begin
        #(8ns * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done === 0 && clr_valid === 0, "R1", "reset outputs", {30'b0, done, clr_valid}, 0);
        chk(result === 32'hFFFF_FFFF, "R1", "reset result", result, 32'hFFFF_FFFF);

        // R7: nothing qualifies on either channel
        do_read(1, 0, "R7");
        do_read(0, 1, "R7");

        // R2: disabled and fast sources excluded from normal
        src(3, 0, 15, 0); en[3] = 1'b0;
        src(5, 1, 15, 0);
        src(10, 0, 1, 0);
        do_read(1, 0, "R2");
        do_read(1, 0, "R2");          // only 3 (disabled) and 5 (fast) left
        do_read(0, 1, "R6");          // fast picks 5
        pend = '0; en = '0; fs = '0;

        // R3: highest priority, R5 word layout
        src(2, 0, 7, 0); src(40, 0, 3, 0); src(63, 0, 5, 0);
        do_read(1, 0, "R3");
        do_read(1, 0, "R3");
        do_read(1, 0, "R5");
        // R4: tie goes to highest index
        src(12, 0, 9, 0); src(50, 0, 9, 0);
        do_read(1, 0, "R4");
        do_read(1, 0, "R4");
        // R3: priority 0 at index 0 still qualifies
        src(0, 0, 0, 0);
        do_read(1, 0, "R3");
        // R5: top index with top priority
        src(63, 0, 15, 0);
        do_read(1, 0, "R5");

        // R6: fast picks lowest, ignores normal sources
        src(60, 1, 0, 0); src(33, 1, 2, 0); src(7, 1, 9, 0); src(1, 0, 15, 0);
        do_read(0, 1, "R6");
        do_read(0, 1, "R6");
        // R10: both strobes serve normal
        do_read(1, 1, "R10");
        do_read(0, 1, "R6");
        do_read(0, 1, "R7");

        // R11: level-held source returns and wins again
        pend = '0; en = '0; fs = '0;
        src(20, 0, 15, 1); src(30, 0, 2, 0);
        do_read(1, 0, "R11");
        do_read(1, 0, "R11");
        lvl[20] = 1'b0;
        do_read(1, 0, "R11");
        do_read(1, 0, "R11");
        do_read(1, 0, "R7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule